// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This block is a programmable interval timer. A prescaler divides an incoming tick-enable pulse (one pulse every fourth oscillator cycle in the intended system) by a programmable modulus. Each time the prescaler rolls over, the main down-counter steps once. When both stages finish their count together, the block raises a one-cycle interrupt pulse. In one-shot mode the counter then halts at zero. In modulo-N mode it reloads the initial value and keeps running, which gives a periodic interrupt.

Software drives the block through a small register bus with separate write and read strobes. The control register loads and starts the count, and it can reload the count at any time. The prescale register sets the modulus and the mode. The count register takes the initial value on a write and returns the live count on a read. None of the pins carries a data stream, so all of them are plain control and status signals with no handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is registered: it appears on `bus_rdata` one cycle after `bus_rd` and stays there until the next read.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, the control register reads 0 (counting disabled), the mode is one-shot, the prescale and initial fields are 0, and `irq_pulse` is low.
- R2: Register map: address 0 is control, address 1 is prescale (write only), address 2 is count, and address 3 reads 0. In the prescale register, bit 0 selects the mode (0 = one-shot, 1 = modulo-N) and bits [PRE_W+1:2] hold the modulus P, where 0 means 2^PRE_W. The counter steps once every P accepted ticks.
- R3: The initial value N ranges from 1 to 2^CNT_W, and a written 0 means 2^CNT_W. After a load with counting enabled, the first interrupt follows the N*P-th accepted tick.
- R4: `irq_pulse` is high for exactly the one cycle after the clock edge on which the tick that ends both the prescaler and the counter is accepted.
- R5: In one-shot mode the counter halts at 0 after its interrupt. It then reads 0 and raises no further interrupt until the next load.
- R6: In modulo-N mode the counter reloads N at end of count and continues, giving an interrupt every N*P ticks.
- R7: In the control register, bit 0 = 1 loads both the counter (with N) and the prescaler (with P). The load bit is self-clearing and always reads 0. Bit 1 enables counting and reads back as written.
- R8: With bit 1 clear, the counter and the prescaler hold their values. Setting bit 1 again without a load resumes from exactly where they stopped.
- R9: A read of address 2 returns the current count and changes neither the count nor the mode. A read of address 1 returns 0.
- R10: A load while counting is enabled restarts the count from N, with the prescaler restarted from P.
- R11: While `tick_en` is low, nothing advances and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler input tick (oscillator/4 enable) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_pulse | output | 1 | One-cycle end-of-count interrupt |

## Verification
The bench builds the timer with PRE_W = 3 and CNT_W = 4, so the prescale modulus covers 1..8 and the initial count covers 1..16. These sizes make an exhaustive sweep of all 128 (P, N) pairs in modulo-N mode short enough to run. The sweep includes the written-zero encodings that stand for the maximum values. For every pair the bench measures the first and second interrupt intervals against N*P. Directed sequences with single tick pulses then cover freezing and resuming, reloading in mid-count, one-shot halting and the read-back rules.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PRESC = 2'd1,
    REG_COUNT = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;

  localparam int CTRL_LOAD_BIT   = 0;
  localparam int CTRL_RUN_BIT    = 1;
  localparam int PRESC_MODE_BIT  = 0;
  localparam int PRESC_FIELD_LSB = 2;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int PRE_W  = 6,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cur_count,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              load_pulse,
  output logic              run_en,
  output logic              modulo_mode,
  output logic [PRE_W-1:0]  presc_mod,
  output logic [CNT_W-1:0]  init_val
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;

  assign sel        = reg_sel_e'(bus_addr);
  assign load_pulse = bus_wr && (sel == REG_CTRL) && bus_wdata[CTRL_LOAD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en      <= 1'b0;
      modulo_mode <= 1'b0;
      presc_mod   <= '0;
      init_val    <= '0;
    end else if (bus_wr) begin
      case (sel)
        REG_CTRL:  run_en <= bus_wdata[CTRL_RUN_BIT];
        REG_PRESC: begin
          modulo_mode <= bus_wdata[PRESC_MODE_BIT];
          presc_mod   <= bus_wdata[PRESC_FIELD_LSB +: PRE_W];
        end
        REG_COUNT: init_val <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_CTRL:  rd_mux[CTRL_RUN_BIT] = run_en;
      REG_COUNT: rd_mux[CNT_W-1:0]    = cur_count;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_load_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == REG_CTRL) |=> (bus_rdata[CTRL_LOAD_BIT] == 1'b0));

  assert_presc_unreadable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == REG_PRESC) |=> (bus_rdata == '0));
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic             run,
  input  logic [PRE_W-1:0] modulo,
  output logic             ovf
);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(1);

  logic [PRE_W-1:0] pre_cnt;

  assign ovf = tick && run && !load && (pre_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (load) begin
      pre_cnt <= modulo;
    end else if (tick && run) begin
      if (pre_cnt == LAST) pre_cnt <= modulo;
      else                 pre_cnt <= pre_cnt - LAST;
    end
  end

  assert_presc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick && run)) |=> $stable(pre_cnt));

  assert_presc_rollover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (pre_cnt == $past(modulo)));
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] init,
  input  logic             reload_mode,
  output logic [CNT_W-1:0] count,
  output logic             halted,
  output logic             expired
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  assign expired = step && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      halted <= 1'b0;
    end else if (load) begin
      count  <= init;
      halted <= 1'b0;
    end else if (step) begin
      if (count == LAST) begin
        if (reload_mode) begin
          count <= init;
        end else begin
          count  <= '0;
          halted <= 1'b1;
        end
      end else begin
        count <= count - LAST;
      end
    end
  end

  assert_oneshot_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load) |=> ($stable(count) && halted));

  assert_load_takes_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(init)));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && reload_mode && !load) |=> (count == $past(init)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int PRE_W  = 6,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse
);
  logic             load_pulse;
  logic             run_en;
  logic             modulo_mode;
  logic [PRE_W-1:0] presc_mod;
  logic [CNT_W-1:0] init_val;
  logic [CNT_W-1:0] count;
  logic             halted;
  logic             expired;
  logic             pre_ovf;
  logic             active;

  assign active = run_en && !halted;

  timer_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cur_count  (count),
    .bus_rdata  (bus_rdata),
    .load_pulse (load_pulse),
    .run_en     (run_en),
    .modulo_mode(modulo_mode),
    .presc_mod  (presc_mod),
    .init_val   (init_val)
  );

  timer_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_pulse),
    .tick  (tick_en),
    .run   (active),
    .modulo(presc_mod),
    .ovf   (pre_ovf)
  );

  timer_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_pulse),
    .step       (pre_ovf),
    .init       (init_val),
    .reload_mode(modulo_mode),
    .count      (count),
    .halted     (halted),
    .expired    (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= expired;
  end

  assert_irq_follows_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(tick_en));

  assert_no_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !irq_pulse);

  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !bus_wr) |=> $stable(count));
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int PRE_W = 3;
  localparam int CNT_W = 4;
  localparam int PM    = 1 << PRE_W;
  localparam int CM    = 1 << CNT_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_pulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tick_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    int first, second, nirq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(irq_pulse == 1'b0, "R1 irq", irq_pulse, 0);
    bus_read(2'd2, rv); chk(rv == 8'd0, "R1 count", rv, 0);
    bus_read(2'd0, rv); chk(rv == 8'd0, "R1 ctrl", rv, 0);

    // R2 R3 R6: exhaustive sweep, modulo-N, tick every cycle
    for (int p = 1; p <= PM; p++) begin
      for (int n = 1; n <= CM; n++) begin
        tick_en = 1'b1;
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'(((p % PM) << 2) | 1));
        bus_write(2'd2, 8'(n % CM));
        bus_write(2'd0, 8'h03);
        first = -1; second = -1;
        for (int k = 1; k <= 2 * n * p + 4; k++) begin
          @(negedge clk);
          if (irq_pulse) begin
            if (first < 0) first = k;
            else if (second < 0) second = k;
          end
        end
        chk(first == n * p, "R2/R3 first period", first, n * p);
        chk(second == 2 * n * p, "R6 reload period", second, 2 * n * p);
      end
    end
    tick_en = 1'b0;
    bus_write(2'd0, 8'h00);

    // R5 one-shot: P=2, N=3
    tick_en = 1'b1;
    bus_write(2'd1, 8'(2 << 2));
    bus_write(2'd2, 8'd3);
    bus_write(2'd0, 8'h03);
    first = -1; nirq = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (irq_pulse) begin nirq++; if (first < 0) first = k; end
    end
    chk(first == 6, "R5 one-shot irq time", first, 6);
    chk(nirq == 1, "R5 single irq", nirq, 1);
    bus_read(2'd2, rv); chk(rv == 8'd0, "R5 halted count", rv, 0);
    tick_en = 1'b0;
    bus_write(2'd0, 8'h00);

    // R8 freeze and resume: P=3, N=5 one-shot, single tick pulses
    bus_write(2'd1, 8'(3 << 2));
    bus_write(2'd2, 8'd5);
    bus_write(2'd0, 8'h03);
    bus_read(2'd0, rv); chk(rv == 8'h02, "R7 ctrl readback", rv, 2);
    pulse_ticks(4);
    bus_read(2'd2, rv); chk(rv == 8'd4, "R8 count before freeze", rv, 4);
    bus_write(2'd0, 8'h00);
    nirq = 0;
    repeat (10) begin pulse_ticks(1); if (irq_pulse) nirq++; end
    bus_read(2'd2, rv); chk(rv == 8'd4, "R8 frozen count", rv, 4);
    chk(nirq == 0, "R8 no irq while disabled", nirq, 0);
    bus_write(2'd0, 8'h02);
    pulse_ticks(10); chk(irq_pulse == 1'b0, "R8 early irq", irq_pulse, 0);
    pulse_ticks(1);  chk(irq_pulse == 1'b1, "R8 resumed irq", irq_pulse, 1);
    @(negedge clk);  chk(irq_pulse == 1'b0, "R4 pulse width", irq_pulse, 0);

    // R10 load mid-count: P=3, N=5 modulo-N
    bus_write(2'd1, 8'((3 << 2) | 1));
    bus_write(2'd0, 8'h03);
    pulse_ticks(7);
    bus_read(2'd2, rv); chk(rv == 8'd3, "R9 live count", rv, 3);
    bus_write(2'd0, 8'h03);
    bus_read(2'd2, rv); chk(rv == 8'd5, "R10 restart count", rv, 5);
    bus_read(2'd2, rv); chk(rv == 8'd5, "R9 read non-destructive", rv, 5);
    pulse_ticks(14); chk(irq_pulse == 1'b0, "R10 early irq", irq_pulse, 0);
    pulse_ticks(1);  chk(irq_pulse == 1'b1, "R10 irq after restart", irq_pulse, 1);

    // R11 no ticks: nothing advances
    nirq = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (irq_pulse) nirq++; end
    chk(nirq == 0, "R11 no irq without ticks", nirq, 0);
    bus_read(2'd2, rv); chk(rv == 8'd5, "R11 count held", rv, 5);

    // R7 R9 read-back rules
    bus_write(2'd0, 8'h01);
    bus_read(2'd0, rv); chk(rv == 8'h00, "R7 load bit self-clears", rv, 0);
    bus_read(2'd1, rv); chk(rv == 8'h00, "R9 prescale reads zero", rv, 0);
    bus_read(2'd3, rv); chk(rv == 8'h00, "R2 spare address", rv, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule